// File: doc/BRIEF.md
# Stack Pointer Unit

This block keeps the 16-bit stack pointer of a small 8-bit processor and turns stack requests into byte-wide memory cycles. One request can be presented at a time. A byte push writes a data byte. A byte pop reads one back. A call stores a two-byte return address. A return fetches that address and rebuilds it. The stack grows toward lower addresses, and the pointer always names the next free byte.

A call stores the return address as a word pointer, which is the byte address shifted right by one. The low byte goes first, at the current pointer. The high byte follows one address lower. Software sees the pointer as two byte-wide I/O registers, selected by a byte-select input. A write to the low register blocks interrupts for a fixed number of retired instructions. Any later I/O write ends that block early, so a two-register pointer update cannot be torn by an interrupt.

The memory has one port and a synchronous read: data requested in one cycle is presented in the next.

Top module: `sp_unit`

## Requirements
- R1: After reset the pointer equals `SP_RESET` (default 0x3FFF), `irq_inhibit` is 0 and `busy` is 0.
- R2: A byte push (`req_op`=0) accepted while idle writes `push_data` at the pointer in the same cycle. The pointer is one lower from the next cycle.
- R3: A byte pop (`req_op`=1) accepted while idle reads the pointer plus one in the same cycle, and the pointer moves up by one from the next cycle. In the next cycle `pop_valid` is 1 and `pop_data` carries the read byte, with `busy` held at 1.
- R4: A call (`req_op`=2) stores the word pointer `ret_addr>>1` in two consecutive write cycles:
  - the first writes bits 7:0 at the pointer;
  - the second writes bits 15:8 at the pointer minus one, with `busy` at 1.
  The pointer holds through the first write cycle and is two lower after the second.
- R5: A return (`req_op`=3) reads the pointer plus one (the high byte), then the pointer plus two (the low byte), on consecutive cycles. In the third cycle `ret_valid` is 1 and `ret_word` is {high, low}. The pointer is two higher from the cycle after that.
- R6: `io_rdata` shows pointer bits 7:0 when `io_byte`=0 and bits 15:8 when `io_byte`=1.
- R7: A cycle with `io_wr`=1 and `io_hit`=1 replaces the selected pointer byte from the next cycle. This write overrides any pointer change from a stack request in the same cycle.
- R8: A request presented while `busy` is 1 is ignored: it causes no memory cycle and no pointer change.
- R9: A write to the low pointer byte raises `irq_inhibit` from the next cycle. `irq_inhibit` stays high until `INHIBIT_INSNS` (default 4) `insn_done` pulses have been counted, and drops in the cycle after the last pulse.
- R10: While `irq_inhibit` is 1, any I/O write other than a low-byte pointer write clears it in the next cycle. A high-byte pointer write never raises it.
- R11: Pointer arithmetic wraps modulo 2^16, and `mem_we` and `mem_re` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Stack request present |
| req_op | input | 2 | 0 push byte, 1 pop byte, 2 call, 3 return |
| push_data | input | 8 | Byte for a push |
| ret_addr | input | 16 | Byte return address for a call |
| busy | output | 1 | Multi-cycle request in progress |
| pop_valid | output | 1 | Popped byte present |
| pop_data | output | 8 | Popped byte |
| ret_valid | output | 1 | Return word present |
| ret_word | output | 16 | Rebuilt word-pointer return address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_re` |
| io_wr | input | 1 | Any I/O register write this cycle |
| io_hit | input | 1 | The I/O access targets the pointer |
| io_byte | input | 1 | 0 low pointer byte, 1 high pointer byte |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Selected pointer byte |
| insn_done | input | 1 | One instruction retired this cycle |
| irq_inhibit | output | 1 | Interrupts must be held off |

## Verification
The bench sweeps several start pointers and return addresses. It checks the byte order and the addresses of both call writes. A design with the byte order reversed, or with the pointer committed after the first write, fails these checks. Other checks cover pops and returns that must read from the pointer plus one before moving it, pointer wrap at zero, a request arriving during a call's second cycle, and an I/O write colliding with a push. The inhibit counter is checked for an off-by-one in the instruction count, for being cut short by a foreign I/O write, and for being raised by a high-byte write.

// File: rtl/sp_unit_pkg.sv
package sp_unit_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_CALL = 2'd2,
        OP_RET  = 2'd3
    } sp_op_e;

    typedef enum logic [2:0] {
        ADJ_HOLD,
        ADJ_DEC1,
        ADJ_DEC2,
        ADJ_INC1,
        ADJ_INC2
    } sp_adj_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALL_HI,
        ST_POP_WAIT,
        ST_RET_HI,
        ST_RET_LO
    } seq_state_e;
endpackage

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg
    import sp_unit_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SP_RESET = 16'h3FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sp_adj_e           adj,
    input  logic              io_we_lo,
    input  logic              io_we_hi,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [ADDR_W-1:0] sp_q
);
    logic [ADDR_W-1:0] sp_d;

    always_comb begin
        sp_d = sp_q;
        unique case (adj)
            ADJ_DEC1: sp_d = sp_q - ADDR_W'(1);
            ADJ_DEC2: sp_d = sp_q - ADDR_W'(2);
            ADJ_INC1: sp_d = sp_q + ADDR_W'(1);
            ADJ_INC2: sp_d = sp_q + ADDR_W'(2);
            default:  sp_d = sp_q;
        endcase
        // software write takes priority over any stack adjustment
        if (io_we_lo) sp_d = {sp_q[ADDR_W-1:BYTE_W], io_wdata};
        if (io_we_hi) sp_d = {io_wdata, sp_q[BYTE_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= SP_RESET;
        else        sp_q <= sp_d;
    end

    // R7: a software byte write lands exactly as written
    assert_io_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we_lo && !io_we_hi) |=> sp_q[BYTE_W-1:0] == $past(io_wdata));
endmodule

// File: rtl/sp_seq.sv
module sp_seq
    import sp_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [BYTE_W-1:0] push_data,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] sp,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output sp_adj_e           adj,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              pop_valid,
    output logic [BYTE_W-1:0] pop_data,
    output logic              ret_valid,
    output logic [ADDR_W-1:0] ret_word
);
    typedef struct packed {
        seq_state_e        state;
        logic [BYTE_W-1:0] hold;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [ADDR_W-1:0] word_ptr;

    assign word_ptr = ret_addr >> 1;

    always_comb begin
        r_d       = r_q;
        adj       = ADJ_HOLD;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp;
        mem_wdata = '0;
        pop_valid = 1'b0;
        pop_data  = '0;
        ret_valid = 1'b0;
        ret_word  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (sp_op_e'(req_op))
                        OP_PUSH: begin
                            mem_we    = 1'b1;
                            mem_wdata = push_data;
                            adj       = ADJ_DEC1;
                        end
                        OP_POP: begin
                            mem_re    = 1'b1;
                            mem_addr  = sp + ADDR_W'(1);
                            adj       = ADJ_INC1;
                            r_d.state = ST_POP_WAIT;
                        end
                        OP_CALL: begin
                            mem_we    = 1'b1;
                            mem_wdata = word_ptr[BYTE_W-1:0];
                            r_d.hold  = word_ptr[ADDR_W-1:BYTE_W];
                            r_d.state = ST_CALL_HI;
                        end
                        OP_RET: begin
                            mem_re    = 1'b1;
                            mem_addr  = sp + ADDR_W'(1);
                            r_d.state = ST_RET_HI;
                        end
                        default: ;
                    endcase
                end
            end
            ST_CALL_HI: begin
                mem_we    = 1'b1;
                mem_addr  = sp - ADDR_W'(1);
                mem_wdata = r_q.hold;
                adj       = ADJ_DEC2;
                r_d.state = ST_IDLE;
            end
            ST_POP_WAIT: begin
                pop_valid = 1'b1;
                pop_data  = mem_rdata;
                r_d.state = ST_IDLE;
            end
            ST_RET_HI: begin
                r_d.hold  = mem_rdata;
                mem_re    = 1'b1;
                mem_addr  = sp + ADDR_W'(2);
                r_d.state = ST_RET_LO;
            end
            ST_RET_LO: begin
                ret_valid = 1'b1;
                ret_word  = {r_q.hold, mem_rdata};
                adj       = ADJ_INC2;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    assign busy = (r_q.state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.hold  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R11: one memory access per cycle
    assert_mem_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R5: returned word appears only right after a read
    assert_ret_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(mem_re));
endmodule

// File: rtl/sp_inhibit.sv
module sp_inhibit #(
    parameter int INHIBIT_INSNS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_lo,
    input  logic io_wr,
    input  logic insn_done,
    output logic irq_inhibit
);
    localparam int CNT_W = $clog2(INHIBIT_INSNS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } inh_regs_t;

    inh_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (set_lo) begin
            r_d.cnt = CNT_W'(INHIBIT_INSNS);
        end else if (r_q.cnt != '0) begin
            if (io_wr)          r_d.cnt = '0;
            else if (insn_done) r_d.cnt = r_q.cnt - CNT_W'(1);
        end
    end

    assign irq_inhibit = (r_q.cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.cnt <= '0;
        else        r_q <= r_d;
    end

    // R9: the low-byte write raises the inhibit
    assert_inhibit_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_lo |=> irq_inhibit);

    // R9: without a retire or an I/O write the inhibit persists
    assert_inhibit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_inhibit && !io_wr && !insn_done) |=> irq_inhibit);

    // R10: a foreign I/O write ends the inhibit
    assert_inhibit_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_inhibit && io_wr && !set_lo) |=> !irq_inhibit);
endmodule

// File: rtl/sp_unit.sv
module sp_unit
    import sp_unit_pkg::*;
#(
    parameter logic [15:0] SP_RESET      = 16'h3FFF,
    parameter int          INHIBIT_INSNS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [7:0]  push_data,
    input  logic [15:0] ret_addr,
    output logic        busy,
    output logic        pop_valid,
    output logic [7:0]  pop_data,
    output logic        ret_valid,
    output logic [15:0] ret_word,
    output logic        mem_we,
    output logic        mem_re,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        io_wr,
    input  logic        io_hit,
    input  logic        io_byte,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic        insn_done,
    output logic        irq_inhibit
);
    logic [ADDR_W-1:0] sp;
    sp_adj_e           adj;
    logic              we_lo, we_hi, sp_io_we, accept;

    assign sp_io_we = io_wr && io_hit;
    assign we_lo    = sp_io_we && !io_byte;
    assign we_hi    = sp_io_we &&  io_byte;
    assign accept   = req_valid && !busy;

    sp_ptr_reg #(.SP_RESET(SP_RESET)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adj      (adj),
        .io_we_lo (we_lo),
        .io_we_hi (we_hi),
        .io_wdata (io_wdata),
        .sp_q     (sp)
    );

    sp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .push_data (push_data),
        .ret_addr  (ret_addr),
        .sp        (sp),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .adj       (adj),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .ret_valid (ret_valid),
        .ret_word  (ret_word)
    );

    sp_inhibit #(.INHIBIT_INSNS(INHIBIT_INSNS)) u_inh (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_lo      (we_lo),
        .io_wr       (io_wr),
        .insn_done   (insn_done),
        .irq_inhibit (irq_inhibit)
    );

    assign io_rdata = io_byte ? sp[ADDR_W-1:BYTE_W] : sp[BYTE_W-1:0];

    // R2: an accepted push lowers the pointer by one
    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == 2'd0 && !sp_io_we) |=> sp == 16'($past(sp) - 16'd1));

    // R4: second call write goes one address below the first
    assert_call_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == 2'd2) |=> (mem_we && mem_addr == 16'($past(mem_addr) - 16'd1)));

    // R4: pointer holds until both call bytes are written
    assert_call_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == 2'd2 && !sp_io_we) |=> $stable(sp));

    // R8: the cycle after a pop is a data cycle, not a new memory access
    assert_busy_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> (!mem_we && !mem_re));
endmodule

// File: tb/tb_sp_unit.sv
module tb_sp_unit;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] EXP_RESET  = 16'h3FFF;
    localparam int          INH_N      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  push_data = 8'd0;
    logic [15:0] ret_addr = 16'd0;
    logic        busy, pop_valid, ret_valid, mem_we, mem_re, irq_inhibit;
    logic [7:0]  pop_data, mem_wdata, io_rdata;
    logic [15:0] ret_word, mem_addr;
    logic [7:0]  mem_rdata = 8'd0;
    logic        io_wr = 1'b0, io_hit = 1'b0, io_byte = 1'b0, insn_done = 1'b0;
    logic [7:0]  io_wdata = 8'd0;

    logic [7:0] mem [256];
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sp_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .push_data(push_data), .ret_addr(ret_addr), .busy(busy),
        .pop_valid(pop_valid), .pop_data(pop_data), .ret_valid(ret_valid),
        .ret_word(ret_word), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_wr(io_wr), .io_hit(io_hit), .io_byte(io_byte), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .insn_done(insn_done), .irq_inhibit(irq_inhibit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // synchronous-read byte memory model, indexed by the low address byte
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_sp(output logic [15:0] v);
        io_byte = 1'b0; #1; v[7:0]  = io_rdata;
        io_byte = 1'b1; #1; v[15:8] = io_rdata;
        io_byte = 1'b0; #1;
    endtask

    task automatic check_sp(input string req, input logic [15:0] exp);
        logic [15:0] v;
        read_sp(v);
        check(req, {16'd0, v}, {16'd0, exp});
    endtask

    task automatic io_write(input logic hit, input logic sel, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_hit = hit; io_byte = sel; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_hit = 1'b0; io_byte = 1'b0;
    endtask

    task automatic set_sp(input logic [15:0] v);
        io_write(1'b1, 1'b1, v[15:8]);
        io_write(1'b1, 1'b0, v[7:0]);
    endtask

    task automatic do_push(input logic [7:0] d, input logic [15:0] sp0);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; push_data = d; #1;
        check("R2 push we", {31'd0, mem_we}, 32'd1);
        check("R2 push addr", {16'd0, mem_addr}, {16'd0, sp0});
        check("R2 push data", {24'd0, mem_wdata}, {24'd0, d});
        @(negedge clk);
        req_valid = 1'b0;
        check_sp("R2 push pointer", 16'(sp0 - 16'd1));
    endtask

    task automatic do_pop(input logic [7:0] exp, input logic [15:0] sp0);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; #1;
        check("R3 pop read addr", {15'd0, mem_re, mem_addr}, {15'd0, 1'b1, 16'(sp0 + 16'd1)});
        @(negedge clk);
        req_valid = 1'b0; #1;
        check("R3 pop data", {22'd0, pop_valid, busy, pop_data}, {22'd0, 1'b1, 1'b1, exp});
        check_sp("R3 pop pointer", 16'(sp0 + 16'd1));
        @(negedge clk); #1;
        check("R3 pop done", {30'd0, pop_valid, busy}, 32'd0);
    endtask

    task automatic do_call(input logic [15:0] ra, input logic [15:0] sp0);
        logic [15:0] wp;
        logic [15:0] v;
        wp = ra >> 1;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2; ret_addr = ra; #1;
        check("R4 call first write", {7'd0, mem_we, mem_addr, mem_wdata}, {7'd0, 1'b1, sp0, wp[7:0]});
        @(negedge clk);
        req_valid = 1'b0; #1;
        check("R4 call second write", {6'd0, busy, mem_we, mem_addr, mem_wdata},
              {6'd0, 1'b1, 1'b1, 16'(sp0 - 16'd1), wp[15:8]});
        read_sp(v);
        check("R4 call pointer held", {16'd0, v}, {16'd0, sp0});
        @(negedge clk);
        check_sp("R4 call pointer final", 16'(sp0 - 16'd2));
        check("R4 call memory bytes", {16'd0, mem[8'(sp0 - 16'd1)], mem[sp0[7:0]]}, {16'd0, wp});
    endtask

    task automatic do_ret(input logic [15:0] exp_wp, input logic [15:0] sp0);
        logic [15:0] v;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; #1;
        check("R5 ret first read", {15'd0, mem_re, mem_addr}, {15'd0, 1'b1, 16'(sp0 + 16'd1)});
        @(negedge clk);
        req_valid = 1'b0; #1;
        check("R5 ret second read", {14'd0, busy, mem_re, mem_addr}, {14'd0, 1'b1, 1'b1, 16'(sp0 + 16'd2)});
        @(negedge clk); #1;
        check("R5 ret word", {15'd0, ret_valid, ret_word}, {15'd0, 1'b1, exp_wp});
        read_sp(v);
        check("R5 ret pointer held", {16'd0, v}, {16'd0, sp0});
        @(negedge clk);
        check_sp("R5 ret pointer final", 16'(sp0 + 16'd2));
    endtask

    task automatic pulse_insn();
        @(negedge clk); insn_done = 1'b1;
        @(negedge clk); insn_done = 1'b0;
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] base;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check_sp("R1 reset pointer", EXP_RESET);
        check("R1 reset flags", {30'd0, irq_inhibit, busy}, 32'd0);

        // R6 byte select
        io_byte = 1'b1; #1;
        check("R6 high byte read", {24'd0, io_rdata}, {24'd0, EXP_RESET[15:8]});
        io_byte = 1'b0; #1;
        check("R6 low byte read", {24'd0, io_rdata}, {24'd0, EXP_RESET[7:0]});

        // sweep start pointers: byte LIFO and call/return
        for (int i = 0; i < 8; i++) begin
            base = 16'h1000 + 16'(i * 37) + 16'h40;
            set_sp(base);
            check_sp("R7 software pointer load", base);
            for (int k = 0; k < 3; k++) do_push(8'(8'hA0 + i * 8 + k), 16'(base - 16'(k)));
            for (int k = 2; k >= 0; k--) do_pop(8'(8'hA0 + i * 8 + k), 16'(base - 16'(k) - 16'd1));
            do_call(16'(16'h1357 * (i + 1) + 16'h0102), base);
            do_call(16'(16'h2468 * (i + 3)), 16'(base - 16'd2));
            do_ret(16'(16'(16'h2468 * (i + 3)) >> 1), 16'(base - 16'd4));
            do_ret(16'(16'(16'h1357 * (i + 1) + 16'h0102) >> 1), 16'(base - 16'd2));
        end

        // R11 wrap at zero
        set_sp(16'h0000);
        do_push(8'h5A, 16'h0000);
        check_sp("R11 wrap down", 16'hFFFF);
        do_pop(8'h5A, 16'hFFFF);
        check_sp("R11 wrap up", 16'h0000);

        // R8 request during call second cycle is ignored
        set_sp(16'h2080);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2; ret_addr = 16'h3456;
        @(negedge clk);
        req_op = 2'd0; push_data = 8'hEE; #1;
        check("R8 busy write keeps call byte", {23'd0, mem_we, mem_wdata}, {23'd0, 1'b1, 8'h1A});
        @(negedge clk);
        req_valid = 1'b0; #1;
        check("R8 no extra memory cycle", {30'd0, mem_we, mem_re}, 32'd0);
        check_sp("R8 pointer unaffected", 16'h207E);

        // R7 software write overrides a push in the same cycle
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; push_data = 8'h11;
        io_wr = 1'b1; io_hit = 1'b1; io_byte = 1'b0; io_wdata = 8'h55;
        @(negedge clk);
        req_valid = 1'b0; io_wr = 1'b0; io_hit = 1'b0;
        check_sp("R7 io write wins", 16'h2055);

        // R9 inhibit lasts exactly INH_N retired instructions
        @(negedge clk); #1;
        check("R9 inhibit raised", {31'd0, irq_inhibit}, 32'd1);
        for (int n = 1; n <= INH_N; n++) begin
            pulse_insn(); #1;
            check("R9 inhibit count", {31'd0, irq_inhibit}, {31'd0, (n < INH_N)});
        end

        // R10 high-byte write does not raise
        io_write(1'b1, 1'b1, 8'h21); #1;
        check("R10 high write no inhibit", {31'd0, irq_inhibit}, 32'd0);
        // R10 foreign I/O write cuts it short
        io_write(1'b1, 1'b0, 8'h40); #1;
        check("R9 inhibit after low write", {31'd0, irq_inhibit}, 32'd1);
        pulse_insn(); #1;
        check("R9 inhibit after one insn", {31'd0, irq_inhibit}, 32'd1);
        io_write(1'b0, 1'b0, 8'h99); #1;
        check("R10 foreign write clears", {31'd0, irq_inhibit}, 32'd0);
        read_sp(v);
        check("R10 foreign write leaves pointer", {16'd0, v}, 32'h2140);
        // R10 high-byte pointer write also clears
        io_write(1'b1, 1'b0, 8'h44);
        io_write(1'b1, 1'b1, 8'h22); #1;
        check("R10 high write clears", {31'd0, irq_inhibit}, 32'd0);
        check_sp("R7 both bytes", 16'h2244);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule